// File: doc/BRIEF.md
# ADC Result Monitor with Accumulator

This block watches the stream of signed conversion results that a converter delivers one strobe at a time. Three independent functions work on that stream. A conversion counter raises a sticky interrupt each time a programmed number of settled results has arrived. A magnitude comparator raises a sticky interrupt when a settled result's absolute value goes past a programmed threshold. A wide accumulator sums the settled results, sign-extended, while it is enabled, and it saturates instead of wrapping.

The count limit and the threshold are loaded through write strobes. The three enables are level inputs. Each interrupt and the overflow flag is cleared by a one-cycle clear pulse. Every output is registered, so an effect shows up on the clock edge that samples the result strobe.

Top module: `adc_result_monitor`

## Requirements
- R1: After reset, cnt_irq_o, thr_irq_o, acc_ovf_o and acc_o are all zero. The count limit resets to 0 and the threshold resets to all ones.
- R2: A result is taken when res_valid_i=1 and res_settled_i=1. While cfg_cnt_en_i=1, cnt_irq_o sets on the N-th taken result counted from enable, from a limit write, or from the previous wrap, where N is the limit (a limit of 0 acts as 1). The counter then restarts at zero. A cycle with cfg_count_we_i=1 loads the limit, restarts the count and does not count that cycle's result.
- R3: cnt_irq_o stays set until a cycle with cnt_irq_clr_i=1. If a new wrap happens in the same cycle as the clear, the flag stays set.
- R4: While cfg_thr_en_i=1, a taken result whose magnitude is strictly greater than the threshold sets thr_irq_o. The threshold is an unsigned 16-bit value, and the magnitude of -32768 is 32768.
- R5: thr_irq_o stays set until a cycle with thr_irq_clr_i=1. A new exceedance in the same cycle as the clear keeps it set.
- R6: While cfg_acc_en_i=1, each taken result is sign-extended and added to acc_o, which is signed two's complement of width ACC_W.
- R7: If a sum would leave the signed ACC_W range, acc_o holds the most positive or most negative value instead and acc_ovf_o sets. Reaching a limit exactly does not set the flag. acc_ovf_o stays set until a cycle with acc_ovf_clr_i=1, and a new overflow in that cycle keeps it set.
- R8: A cycle with cfg_acc_en_i=0 forces acc_o to zero at the next edge and leaves acc_ovf_o unchanged.
- R9: A result presented with res_valid_i=1 and res_settled_i=0 is unsettled. The counter, the comparator and the accumulator all ignore it.
- R10: With cfg_cnt_en_i=0 the counter is held at zero and cnt_irq_o never sets. With cfg_thr_en_i=0 thr_irq_o never sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_valid_i | input | 1 | Result strobe |
| res_settled_i | input | 1 | Strobed result is settled |
| res_data_i | input | DATA_W | Signed result |
| cfg_count_we_i | input | 1 | Load count limit |
| cfg_count_i | input | CNT_W | Count limit value |
| cfg_thr_we_i | input | 1 | Load threshold |
| cfg_thr_i | input | DATA_W | Unsigned magnitude threshold |
| cfg_cnt_en_i | input | 1 | Counter enable |
| cfg_thr_en_i | input | 1 | Comparator enable |
| cfg_acc_en_i | input | 1 | Accumulator enable |
| cnt_irq_clr_i | input | 1 | Clear count interrupt |
| thr_irq_clr_i | input | 1 | Clear threshold interrupt |
| acc_ovf_clr_i | input | 1 | Clear overflow flag |
| cnt_irq_o | output | 1 | Sticky count interrupt |
| thr_irq_o | output | 1 | Sticky threshold interrupt |
| acc_o | output | ACC_W | Accumulator value |
| acc_ovf_o | output | 1 | Sticky saturation flag |

## Verification
The assertions take for granted that res_data_i is valid two's complement whenever the strobe is high and that no input changes between clock edges. The checks on the count wrap and the accumulator also assume that a limit write and the enables are not toggled by glitches. The bench keeps within these assumptions by driving every input only on the falling edge and by holding limit writes apart from result strobes. It runs the accumulator at a narrow width so that saturation is reached in a few dozen results.

// File: rtl/adc_mon_pkg.sv
package adc_mon_pkg;
  typedef enum logic [1:0] {SAT_NONE, SAT_POS, SAT_NEG} sat_e;
endpackage

// File: rtl/amon_conv_counter.sv
module amon_conv_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             take_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             clr_i,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] tgt;
  logic             hit;

  assign tgt = (limit_i == '0) ? CNT_W'(1) : limit_i;
  assign hit = en_i && !restart_i && take_i && (cnt_q == tgt - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!en_i || restart_i) cnt_q <= '0;
    else if (hit)                cnt_q <= '0;
    else if (take_i)             cnt_q <= cnt_q + CNT_W'(1);
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_o <= 1'b0;
    else if (hit)   irq_o <= 1'b1;
    else if (clr_i) irq_o <= 1'b0;
  end
endmodule

// File: rtl/amon_thresh_cmp.sv
module amon_thresh_cmp #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              take_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] thr_i,
  input  logic              clr_i,
  output logic              irq_o
);
  logic [DATA_W:0] mag;
  logic            over;

  // one extra bit so the most negative value keeps its magnitude
  assign mag  = data_i[DATA_W-1] ? ({1'b0, ~data_i} + (DATA_W+1)'(1)) : {1'b0, data_i};
  assign over = en_i && take_i && (mag > {1'b0, thr_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_o <= 1'b0;
    else if (over)  irq_o <= 1'b1;
    else if (clr_i) irq_o <= 1'b0;
  end
endmodule

// File: rtl/amon_accum.sv
module amon_accum
  import adc_mon_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              take_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              clr_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic              ovf_o
);
  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0] sext;
  logic [ACC_W:0]   sum;
  sat_e             sat;

  generate
    if (ACC_W > DATA_W) begin : g_ext
      assign sext = {{(ACC_W-DATA_W){data_i[DATA_W-1]}}, data_i};
    end else begin : g_same
      assign sext = ACC_W'(data_i);
    end
  endgenerate

  assign sum = {acc_o[ACC_W-1], acc_o} + {sext[ACC_W-1], sext};

  always_comb begin
    if (sum[ACC_W] == sum[ACC_W-1]) sat = SAT_NONE;
    else if (sum[ACC_W])            sat = SAT_NEG;
    else                            sat = SAT_POS;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_o <= '0;
    else if (!en_i)  acc_o <= '0;
    else if (take_i) begin
      case (sat)
        SAT_POS: acc_o <= ACC_MAX;
        SAT_NEG: acc_o <= ACC_MIN;
        default: acc_o <= sum[ACC_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               ovf_o <= 1'b0;
    else if (en_i && take_i && sat != SAT_NONE) ovf_o <= 1'b1;
    else if (clr_i)                            ovf_o <= 1'b0;
  end
endmodule

// File: rtl/adc_result_monitor.sv
module adc_result_monitor #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              res_valid_i,
  input  logic              res_settled_i,
  input  logic [DATA_W-1:0] res_data_i,
  input  logic              cfg_count_we_i,
  input  logic [CNT_W-1:0]  cfg_count_i,
  input  logic              cfg_thr_we_i,
  input  logic [DATA_W-1:0] cfg_thr_i,
  input  logic              cfg_cnt_en_i,
  input  logic              cfg_thr_en_i,
  input  logic              cfg_acc_en_i,
  input  logic              cnt_irq_clr_i,
  input  logic              thr_irq_clr_i,
  input  logic              acc_ovf_clr_i,
  output logic              cnt_irq_o,
  output logic              thr_irq_o,
  output logic [ACC_W-1:0]  acc_o,
  output logic              acc_ovf_o
);
  logic              take;
  logic [CNT_W-1:0]  lim_q;
  logic [DATA_W-1:0] thr_q;

  assign take = res_valid_i & res_settled_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             lim_q <= '0;
    else if (cfg_count_we_i) lim_q <= cfg_count_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           thr_q <= '1;
    else if (cfg_thr_we_i) thr_q <= cfg_thr_i;
  end

  amon_conv_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (cfg_cnt_en_i),
    .take_i    (take),
    .restart_i (cfg_count_we_i),
    .limit_i   (lim_q),
    .clr_i     (cnt_irq_clr_i),
    .irq_o     (cnt_irq_o)
  );

  amon_thresh_cmp #(.DATA_W(DATA_W)) u_thr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cfg_thr_en_i),
    .take_i (take),
    .data_i (res_data_i),
    .thr_i  (thr_q),
    .clr_i  (thr_irq_clr_i),
    .irq_o  (thr_irq_o)
  );

  amon_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cfg_acc_en_i),
    .take_i (take),
    .data_i (res_data_i),
    .clr_i  (acc_ovf_clr_i),
    .acc_o  (acc_o),
    .ovf_o  (acc_ovf_o)
  );
endmodule

// File: rtl/adc_result_monitor_chk.sv
module adc_result_monitor_chk #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              res_valid_i,
  input logic              res_settled_i,
  input logic [DATA_W-1:0] res_data_i,
  input logic              cfg_cnt_en_i,
  input logic              cfg_thr_en_i,
  input logic              cfg_acc_en_i,
  input logic              cnt_irq_clr_i,
  input logic              thr_irq_clr_i,
  input logic              acc_ovf_clr_i,
  input logic              cnt_irq_o,
  input logic              thr_irq_o,
  input logic [ACC_W-1:0]  acc_o,
  input logic              acc_ovf_o,
  input logic [DATA_W-1:0] thr_q_i
);
  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [DATA_W:0] sx;
  logic        [DATA_W:0] mag_c;
  logic                   took;

  assign sx    = {res_data_i[DATA_W-1], res_data_i};
  assign mag_c = sx[DATA_W] ? -sx : sx;
  assign took  = res_valid_i && res_settled_i;

  a_r2_cnt_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cnt_irq_o) |-> $past(took && cfg_cnt_en_i));

  a_r3_cnt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_irq_o && !cnt_irq_clr_i) |=> cnt_irq_o);

  a_r4_thr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (took && cfg_thr_en_i && (mag_c > {1'b0, thr_q_i})) |=> thr_irq_o);

  a_r5_thr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_irq_o && !thr_irq_clr_i) |=> thr_irq_o);

  a_r6_acc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_acc_en_i && !took) |=> $stable(acc_o));

  a_r7_sat_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(acc_ovf_o) |-> (acc_o == ACC_MAX || acc_o == ACC_MIN));

  a_r7_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_ovf_o && !acc_ovf_clr_i) |=> acc_ovf_o);

  a_r8_acc_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_acc_en_i |=> (acc_o == '0));

  a_r9_thr_unsettled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!thr_irq_o && !took) |=> !thr_irq_o);

  a_r10_thr_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!thr_irq_o && !cfg_thr_en_i) |=> !thr_irq_o);

  a_r10_cnt_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_irq_o && !cfg_cnt_en_i) |=> !cnt_irq_o);
endmodule

bind adc_result_monitor adc_result_monitor_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .res_valid_i   (res_valid_i),
  .res_settled_i (res_settled_i),
  .res_data_i    (res_data_i),
  .cfg_cnt_en_i  (cfg_cnt_en_i),
  .cfg_thr_en_i  (cfg_thr_en_i),
  .cfg_acc_en_i  (cfg_acc_en_i),
  .cnt_irq_clr_i (cnt_irq_clr_i),
  .thr_irq_clr_i (thr_irq_clr_i),
  .acc_ovf_clr_i (acc_ovf_clr_i),
  .cnt_irq_o     (cnt_irq_o),
  .thr_irq_o     (thr_irq_o),
  .acc_o         (acc_o),
  .acc_ovf_o     (acc_ovf_o),
  .thr_q_i       (thr_q)
);

// File: tb/sim_adc_result_monitor.sv
`timescale 1ns/1ps
module sim_adc_result_monitor;
  localparam int DW = 16;
  localparam int AW = 20;
  localparam int CW = 4;
  localparam int AMAX = (1 << (AW-1)) - 1;
  localparam int AMIN = -(1 << (AW-1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic res_valid = 0, res_settled = 0;
  logic [DW-1:0] res_data = '0;
  logic cnt_we = 0, thr_we = 0;
  logic [CW-1:0] cnt_val = '0;
  logic [DW-1:0] thr_val = '0;
  logic cnt_en = 0, thr_en = 0, acc_en = 0;
  logic cnt_clr = 0, thr_clr = 0, ovf_clr = 0;
  logic cnt_irq, thr_irq, acc_ovf;
  logic signed [AW-1:0] acc;

  int checks = 0, errors = 0;
  bit done = 0;

  int m_lim = 0, m_cnt = 0, m_thr = 65535, m_acc = 0;
  bit m_cnt_irq = 0, m_thr_irq = 0, m_ovf = 0;

  always #5 clk = ~clk;

  adc_result_monitor #(.DATA_W(DW), .ACC_W(AW), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .res_valid_i(res_valid), .res_settled_i(res_settled), .res_data_i(res_data),
    .cfg_count_we_i(cnt_we), .cfg_count_i(cnt_val),
    .cfg_thr_we_i(thr_we), .cfg_thr_i(thr_val),
    .cfg_cnt_en_i(cnt_en), .cfg_thr_en_i(thr_en), .cfg_acc_en_i(acc_en),
    .cnt_irq_clr_i(cnt_clr), .thr_irq_clr_i(thr_clr), .acc_ovf_clr_i(ovf_clr),
    .cnt_irq_o(cnt_irq), .thr_irq_o(thr_irq), .acc_o(acc), .acc_ovf_o(acc_ovf)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check({req, " cnt_irq"}, int'(cnt_irq), int'(m_cnt_irq));
    check({req, " thr_irq"}, int'(thr_irq), int'(m_thr_irq));
    check({req, " acc"}, int'(acc), m_acc);
    check({req, " acc_ovf"}, int'(acc_ovf), int'(m_ovf));
  endtask

  // one clock: model clears, then the event, then the edge
  task automatic cyc(input bit v, input int d, input bit s);
    int tgt;
    int mag;
    res_valid = v; res_settled = s; res_data = d[DW-1:0];
    if (cnt_clr) m_cnt_irq = 0;
    if (thr_clr) m_thr_irq = 0;
    if (ovf_clr) m_ovf = 0;
    if (!cnt_en || cnt_we) m_cnt = 0;
    if (!acc_en) m_acc = 0;
    if (v && s) begin
      tgt = (m_lim == 0) ? 1 : m_lim;
      if (cnt_en && !cnt_we) begin
        if (m_cnt == tgt - 1) begin m_cnt = 0; m_cnt_irq = 1; end
        else m_cnt++;
      end
      mag = (d < 0) ? -d : d;
      if (thr_en && mag > m_thr) m_thr_irq = 1;
      if (acc_en) begin
        m_acc = m_acc + d;
        if (m_acc > AMAX) begin m_acc = AMAX; m_ovf = 1; end
        if (m_acc < AMIN) begin m_acc = AMIN; m_ovf = 1; end
      end
    end
    @(negedge clk);
    res_valid = 0; res_settled = 0;
    cnt_we = 0; thr_we = 0;
    cnt_clr = 0; thr_clr = 0; ovf_clr = 0;
  endtask

  task automatic set_lim(input int v);
    cnt_we = 1; cnt_val = v[CW-1:0]; m_lim = v;
    cyc(0, 0, 0);
  endtask

  task automatic set_thr(input int v);
    thr_we = 1; thr_val = v[DW-1:0]; m_thr = v;
    cyc(0, 0, 0);
  endtask

  task automatic clear_all();
    cnt_clr = 1; thr_clr = 1; ovf_clr = 1;
    cyc(0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int thr_list [7] = '{0, 1, 100, 32766, 32767, 32768, 65535};
    int lim_list [5] = '{0, 1, 2, 5, 15};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1 reset");

    // R1: reset threshold is all ones, so even -32768 must not trip it
    thr_en = 1;
    cyc(1, -32768, 1);
    check("R1 reset threshold", int'(thr_irq), 0);

    // R4/R5 threshold sweep, counter and accumulator off
    foreach (thr_list[i]) begin
      set_thr(thr_list[i]);
      for (int k = 0; k < 80; k++) begin
        int d;
        int t;
        t = thr_list[i];
        case (k)
          71: d = (t > 32767) ? 32767 : t;
          72: d = (t > 32768) ? -32768 : -t;
          73: d = (t + 1 > 32767) ? 32767 : t + 1;
          74: d = (t + 1 > 32768) ? -32768 : -(t + 1);
          75: d = (t - 1 < 0) ? 0 : t - 1;
          76: d = -32768;
          77: d = 32767;
          78: d = 0;
          79: d = -1;
          default: d = -32768 + k * 923;
        endcase
        cyc(1, d, 1);
        check("R4 threshold compare", int'(thr_irq), int'(m_thr_irq));
        check("R6 acc idle while disabled", int'(acc), 0);
        if (m_thr_irq) begin
          thr_clr = 1;
          cyc(0, 0, 0);
          check("R5 thr clear", int'(thr_irq), 0);
        end
      end
    end

    // R5 set wins over clear; sticky while idle
    set_thr(10);
    cyc(1, 11, 1);
    cyc(0, 0, 0);
    check("R5 thr sticky", int'(thr_irq), 1);
    thr_clr = 1;
    cyc(1, -11, 1);
    check("R5 thr set wins", int'(thr_irq), 1);
    clear_all();

    // R9 unsettled ignored by comparator
    cyc(1, 30000, 0);
    check("R9 thr unsettled", int'(thr_irq), 0);

    // R10 comparator disabled
    thr_en = 0;
    cyc(1, 30000, 1);
    check("R10 thr disabled", int'(thr_irq), 0);

    // R2 counter with several limits, unsettled results mixed in (R9)
    cnt_en = 1;
    foreach (lim_list[i]) begin
      int n;
      set_lim(lim_list[i]);
      n = (lim_list[i] == 0) ? 1 : lim_list[i];
      for (int k = 0; k < 3 * n + 2; k++) begin
        bit s;
        s = (k % 3 != 2);
        cyc(1, k, s);
        check(s ? "R2 count wrap" : "R9 count unsettled", int'(cnt_irq), int'(m_cnt_irq));
        if (m_cnt_irq) begin
          cyc(0, 0, 0);
          check("R3 cnt sticky", int'(cnt_irq), 1);
          cnt_clr = 1;
          cyc(0, 0, 0);
          check("R3 cnt clear", int'(cnt_irq), 0);
        end
      end
    end

    // R3 set wins over clear, limit 1
    set_lim(1);
    cyc(1, 5, 1);
    check("R3 cnt set", int'(cnt_irq), 1);
    cnt_clr = 1;
    cyc(1, 5, 1);
    check("R3 cnt set wins", int'(cnt_irq), 1);
    clear_all();

    // R2 limit write restarts count
    set_lim(3);
    cyc(1, 1, 1);
    cyc(1, 1, 1);
    set_lim(3);
    cyc(1, 1, 1);
    cyc(1, 1, 1);
    check("R2 restart on write", int'(cnt_irq), 0);
    cyc(1, 1, 1);
    check("R2 wrap after restart", int'(cnt_irq), 1);
    clear_all();

    // R10 counter disabled
    cnt_en = 0;
    set_lim(1);
    cyc(1, 1, 1);
    check("R10 cnt disabled", int'(cnt_irq), 0);

    // R6 accumulation
    acc_en = 1;
    cyc(0, 0, 0);
    cyc(1, 1000, 1);  check("R6 add positive", int'(acc), m_acc);
    cyc(1, -3000, 1); check("R6 add negative", int'(acc), m_acc);
    cyc(1, 32767, 1); check("R6 add max", int'(acc), m_acc);
    cyc(1, -32768, 1); check("R6 add min", int'(acc), m_acc);
    cyc(1, 12345, 0); check("R9 acc unsettled", int'(acc), m_acc);

    // R7 positive saturation
    for (int k = 0; k < 20; k++) begin
      cyc(1, 32767, 1);
      check("R7 pos saturate acc", int'(acc), m_acc);
      check("R7 pos saturate ovf", int'(acc_ovf), int'(m_ovf));
    end
    check("R7 at max", int'(acc), AMAX);
    ovf_clr = 1;
    cyc(0, 0, 0);
    check("R7 ovf clear", int'(acc_ovf), 0);
    check("R7 acc kept after clear", int'(acc), AMAX);
    cyc(1, -5, 1);
    check("R7 leave saturation", int'(acc), AMAX - 5);

    // R8 disable zeroes acc and keeps ovf
    cyc(1, 32767, 1);
    cyc(1, 32767, 1);
    check("R7 ovf again", int'(acc_ovf), 1);
    acc_en = 0;
    cyc(1, 100, 1);
    check("R8 acc zeroed", int'(acc), 0);
    check("R8 ovf kept", int'(acc_ovf), 1);
    ovf_clr = 1;
    cyc(0, 0, 0);

    // R7 negative: exactly MIN does not flag, one more does
    acc_en = 1;
    cyc(0, 0, 0);
    for (int k = 0; k < 17; k++) begin
      cyc(1, -32768, 1);
      check("R7 neg saturate acc", int'(acc), m_acc);
      check("R7 neg saturate ovf", int'(acc_ovf), int'(m_ovf));
    end
    check("R7 at min", int'(acc), AMIN);

    check_all("R1 final state model");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule